// File: doc/BRIEF.md
# On-Screen-Display Colour Overlay Mixer

This block sits in the pixel path of a video encoder, after input capture and before colour-space conversion. Every cycle of the internal basic clock it takes one pixel as three 8-bit components (red, green, blue), an overlay switch and a 3-bit overlay colour. It produces three 9-bit output channels one cycle later. With the switch low, the picture passes unchanged. With the switch high, the pixel is replaced by one of eight saturated colours, chosen by the overlay bits. Code zero gives black, which is used for blanking behind text.

A pass-through mode bypasses the overlay. Each output channel then carries its raw 8-bit component in the upper bits and that component's overlay bit in the lowest bit. Red goes to the luma channel, green to the composite channel and blue to the chroma channel. The switch and the overlay bits are registered together with the pixel, so the overlay stays aligned to the pixel it belongs to.

Top module: `osd_overlay_mixer`

## Requirements
- R1: While rst_n is low, all three output channels read zero.
- R2: In normal mode (thru_mode=0) with osd_sw=0, each channel's bits 8..1 equal its video component (luma=red, composite=green, chroma=blue), whatever the overlay bits are.
- R3: In normal mode with osd_sw=1, the code {osd_r,osd_g,osd_b} (osd_r is the MSB) selects the output colour: 000 black, 001 blue, 010 green, 011 cyan, 100 red, 101 magenta, 110 yellow, 111 white. The video input has no effect.
- R4: In normal mode with osd_sw=1, each component of the overlay colour is 0x00 or 0xFF: all ones when that channel's code bit is 1 and all zeros otherwise.
- R5: In pass-through mode (thru_mode=1), out_y={vid_r,osd_r}, out_v={vid_g,osd_g} and out_c={vid_b,osd_b}, whatever osd_sw is.
- R6: Outputs reflect the inputs sampled at the previous rising clock edge, one cycle of latency, with no mixing between consecutive pixels.
- R7: In normal mode, bit 0 of every output channel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal basic clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| vid_r | input | 8 | Red video component |
| vid_g | input | 8 | Green video component |
| vid_b | input | 8 | Blue video component |
| osd_sw | input | 1 | Overlay switch; overlay colour bits are honoured only while high |
| osd_r | input | 1 | Overlay red bit (code MSB) |
| osd_g | input | 1 | Overlay green bit |
| osd_b | input | 1 | Overlay blue bit (code LSB) |
| thru_mode | input | 1 | 1 selects RGB pass-through packing |
| out_y | output | 9 | Luma channel (red path) |
| out_v | output | 9 | Composite channel (green path) |
| out_c | output | 9 | Chroma channel (blue path) |

## Verification
All sixteen combinations of switch and colour code are applied in normal mode and in pass-through mode. The video behind each combination uses distinct values per component, so a swapped channel or a misplaced overlay bit shows in the output. In normal mode, the switch-low cases show that the overlay bits are ignored and the switch-high cases show that the video is ignored. The pass-through cases show that the switch has no effect and that the raw overlay bits land in bit 0. Back-to-back pixels with changing switch and mode expose any latency or alignment error, and a check during reset covers the cleared outputs.

// File: rtl/osd_overlay_pkg.sv
package osd_overlay_pkg;

    typedef enum logic [2:0] {
        OSD_BLACK   = 3'b000,
        OSD_BLUE    = 3'b001,
        OSD_GREEN   = 3'b010,
        OSD_CYAN    = 3'b011,
        OSD_RED     = 3'b100,
        OSD_MAGENTA = 3'b101,
        OSD_YELLOW  = 3'b110,
        OSD_WHITE   = 3'b111
    } osd_code_e;

    localparam int unsigned NUM_CHAN = 3;

endpackage

// File: rtl/osd_palette.sv
module osd_palette
    import osd_overlay_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  osd_code_e              code,
    output logic [PIX_W-1:0]       pal_r,
    output logic [PIX_W-1:0]       pal_g,
    output logic [PIX_W-1:0]       pal_b
);
    localparam logic [PIX_W-1:0] FULL = {PIX_W{1'b1}};
    localparam logic [PIX_W-1:0] NONE = '0;

    always_comb begin
        unique case (code)
            OSD_BLACK:   begin pal_r = NONE; pal_g = NONE; pal_b = NONE; end
            OSD_BLUE:    begin pal_r = NONE; pal_g = NONE; pal_b = FULL; end
            OSD_GREEN:   begin pal_r = NONE; pal_g = FULL; pal_b = NONE; end
            OSD_CYAN:    begin pal_r = NONE; pal_g = FULL; pal_b = FULL; end
            OSD_RED:     begin pal_r = FULL; pal_g = NONE; pal_b = NONE; end
            OSD_MAGENTA: begin pal_r = FULL; pal_g = NONE; pal_b = FULL; end
            OSD_YELLOW:  begin pal_r = FULL; pal_g = FULL; pal_b = NONE; end
            default:     begin pal_r = FULL; pal_g = FULL; pal_b = FULL; end
        endcase
    end
endmodule

// File: rtl/osd_chan_pack.sv
module osd_chan_pack #(
    parameter int unsigned PIX_W = 8
) (
    input  logic             thru,
    input  logic             sw,
    input  logic [PIX_W-1:0] vid,
    input  logic [PIX_W-1:0] pal,
    input  logic             osd_bit,
    output logic [PIX_W:0]   word
);
    always_comb begin
        if (thru) begin
            word = {vid, osd_bit};
        end else if (sw) begin
            word = {pal, 1'b0};
        end else begin
            word = {vid, 1'b0};
        end
    end
endmodule

// File: rtl/osd_overlay_mixer.sv
module osd_overlay_mixer
    import osd_overlay_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] vid_r,
    input  logic [PIX_W-1:0] vid_g,
    input  logic [PIX_W-1:0] vid_b,
    input  logic             osd_sw,
    input  logic             osd_r,
    input  logic             osd_g,
    input  logic             osd_b,
    input  logic             thru_mode,
    output logic [PIX_W:0]   out_y,
    output logic [PIX_W:0]   out_v,
    output logic [PIX_W:0]   out_c
);
    localparam int unsigned WORD_W = PIX_W + 1;

    typedef struct packed {
        logic [NUM_CHAN-1:0][WORD_W-1:0] chan;
        logic                            armed;
    } state_t;

    state_t state_d, state_q;

    logic [PIX_W-1:0]  pal_r, pal_g, pal_b;
    logic [PIX_W-1:0]  vid_arr [NUM_CHAN];
    logic [PIX_W-1:0]  pal_arr [NUM_CHAN];
    logic              bit_arr [NUM_CHAN];
    logic [WORD_W-1:0] word_arr [NUM_CHAN];

    osd_palette #(.PIX_W(PIX_W)) i_palette (
        .code  (osd_code_e'({osd_r, osd_g, osd_b})),
        .pal_r (pal_r),
        .pal_g (pal_g),
        .pal_b (pal_b)
    );

    assign vid_arr[0] = vid_r;
    assign vid_arr[1] = vid_g;
    assign vid_arr[2] = vid_b;
    assign pal_arr[0] = pal_r;
    assign pal_arr[1] = pal_g;
    assign pal_arr[2] = pal_b;
    assign bit_arr[0] = osd_r;
    assign bit_arr[1] = osd_g;
    assign bit_arr[2] = osd_b;

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        osd_chan_pack #(.PIX_W(PIX_W)) i_pack (
            .thru    (thru_mode),
            .sw      (osd_sw),
            .vid     (vid_arr[ch]),
            .pal     (pal_arr[ch]),
            .osd_bit (bit_arr[ch]),
            .word    (word_arr[ch])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int ch = 0; ch < NUM_CHAN; ch++) begin
            state_d.chan[ch] = word_arr[ch];
        end
        state_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_y = state_q.chan[0];
    assign out_v = state_q.chan[1];
    assign out_c = state_q.chan[2];

    // armed means the previous edge was out of reset, so $past inputs are meaningful
    AST_VIDEO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.armed && !$past(thru_mode) && !$past(osd_sw)) |->
        (out_y[PIX_W:1] == $past(vid_r) && out_v[PIX_W:1] == $past(vid_g)
         && out_c[PIX_W:1] == $past(vid_b))) else $error("video pass"); // R2

    AST_OVERLAY_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.armed && !$past(thru_mode) && $past(osd_sw)) |->
        (out_y[PIX_W:1] == {PIX_W{$past(osd_r)}} && out_v[PIX_W:1] == {PIX_W{$past(osd_g)}}
         && out_c[PIX_W:1] == {PIX_W{$past(osd_b)}})) else $error("overlay colour"); // R4

    AST_THRU_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.armed && $past(thru_mode)) |->
        (out_y == {$past(vid_r), $past(osd_r)} && out_v == {$past(vid_g), $past(osd_g)}
         && out_c == {$past(vid_b), $past(osd_b)})) else $error("thru pack"); // R5

    AST_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.armed && !$past(thru_mode)) |->
        (out_y[0] == 1'b0 && out_v[0] == 1'b0 && out_c[0] == 1'b0)) else $error("lsb clear"); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (out_y == '0 && out_v == '0 && out_c == '0)) else $error("reset clear"); // R1
endmodule

// File: tb/test_osd_overlay_mixer.sv
module test_osd_overlay_mixer;
    localparam int PIX_W = 8;
    localparam int WDOG  = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PIX_W-1:0] vid_r = '0, vid_g = '0, vid_b = '0;
    logic             osd_sw = 1'b0, osd_r = 1'b0, osd_g = 1'b0, osd_b = 1'b0;
    logic             thru_mode = 1'b0;
    logic [PIX_W:0]   out_y, out_v, out_c;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int             stamp;
        logic [PIX_W:0] y, v, c;
        string          req;
    } exp_t;
    exp_t sb[$];

    osd_overlay_mixer #(.PIX_W(PIX_W)) i_osd_overlay_mixer (
        .clk(clk), .rst_n(rst_n),
        .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
        .osd_sw(osd_sw), .osd_r(osd_r), .osd_g(osd_g), .osd_b(osd_b),
        .thru_mode(thru_mode),
        .out_y(out_y), .out_v(out_v), .out_c(out_c)
    );

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [3*(PIX_W+1)-1:0] act, logic [3*(PIX_W+1)-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: applies one pixel and queues its expected result
    task automatic drive(bit thru, bit sw, logic [2:0] code,
                         logic [7:0] r, logic [7:0] g, logic [7:0] b, string req);
        exp_t e;
        @(posedge clk);
        #2;
        vid_r = r; vid_g = g; vid_b = b;
        osd_sw = sw; {osd_r, osd_g, osd_b} = code; thru_mode = thru;
        e.stamp = cyc;
        e.req = req;
        if (thru) begin
            e.y = {r, code[2]}; e.v = {g, code[1]}; e.c = {b, code[0]};
        end else if (sw) begin
            e.y = {{8{code[2]}}, 1'b0}; e.v = {{8{code[1]}}, 1'b0}; e.c = {{8{code[0]}}, 1'b0};
        end else begin
            e.y = {r, 1'b0}; e.v = {g, 1'b0}; e.c = {b, 1'b0};
        end
        sb.push_back(e);
    endtask

    // monitor: compares each queued item once its capture edge has passed
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].stamp < cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, {out_y, out_v, out_c}, {e.y, e.v, e.c});
        end
    end

    always @(posedge clk) begin
        if (!done && cyc > WDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        vid_r = 8'hA5; vid_g = 8'h3C; vid_b = 8'h96;
        osd_sw = 1'b1; {osd_r, osd_g, osd_b} = 3'b111; thru_mode = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset clears outputs", {out_y, out_v, out_c}, '0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R7: every switch/code combination in both modes
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 16; k++) begin
                logic [7:0] r, g, b;
                r = 8'h11 * 8'(k) ^ 8'h5A;
                g = 8'h23 + 8'(k * 7);
                b = ~r;
                drive(m[0], k[3], k[2:0], r, g, b,
                      m == 1 ? "R5 thru packing" : (k[3] ? "R3 R4 R7 overlay colour" : "R2 R7 video pass"));
            end
        end
        // R6: back-to-back alternation of mode and switch
        for (int i = 0; i < 24; i++) begin
            drive(i % 3 == 0, i % 2 == 1, 3'(i * 5), 8'(i * 29), 8'(i * 13 + 1), 8'(255 - i * 9),
                  "R6 one-cycle alignment");
        end
        // R2: switch low with every code must not disturb video
        drive(1'b0, 1'b0, 3'b111, 8'h00, 8'hFF, 8'h80, "R2 codes ignored");
        drive(1'b0, 1'b0, 3'b101, 8'h01, 8'h02, 8'h03, "R2 codes ignored");
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule